// File: doc/BRIEF.md
# Class-D Output Stage Supervisor

This block supervises a two-channel bridge-tied class-D power stage. It takes two operating-mode requests from board pins (a wake level and an unmute level) together with five fault flags from the analog sensing: supply overvoltage, supply undervoltage, output overcurrent, an early thermal warning and a thermal shutdown. It picks one operating state for the stage and drives four controls from that state: stage enable, high-impedance command, a forced 50% duty (mute) command and a diagnostic release that models an open-drain pin.

Each fault class recovers in its own way. Supply and thermal-shutdown faults hold the outputs in high impedance only while their flags are set. Overcurrent holds them off for a fixed number of cycles, enables the stage for a single probe cycle and checks the flag again. The thermal warning does not turn the stage off: it drops it to mute. Every input passes through a two-flop synchroniser before the state machine sees it.

States: `ST_STANDBY`, `ST_MUTE`, `ST_PLAY`, `ST_WARN_MUTE`, `ST_FLT_SUPPLY`, `ST_FLT_THERM`, `ST_OC_WAIT`, `ST_OC_PROBE`. Transitions are evaluated every cycle, in this order. Thermal shutdown sends any state to `ST_FLT_THERM`. A supply fault then sends any state to `ST_FLT_SUPPLY`. `ST_OC_WAIT` stays put until the retry count expires, then moves to `ST_OC_PROBE`. `ST_OC_PROBE` goes back to `ST_OC_WAIT` if the overcurrent flag is still set. From any other state, overcurrent enters `ST_OC_WAIT`. If none of these applies, the mode decode chooses: no wake gives `ST_STANDBY`; a thermal warning gives `ST_WARN_MUTE`; no unmute gives `ST_MUTE`; otherwise `ST_PLAY`.

Top module: `amp_supervisor`

## Requirements
- R1: While wake_i is 0 and no fault flag is set, the outputs are stage_en_o=0, hiz_o=1, mute50_o=0, diag_rel_o=0, whatever the value of unmute_i.
- R2: With wake_i=1, unmute_i=0 and no fault flag set, the outputs are stage_en_o=1, hiz_o=0, mute50_o=1, diag_rel_o=0.
- R3: With wake_i=1, unmute_i=1 and no fault flag set, the outputs are stage_en_o=1, hiz_o=0, mute50_o=0, diag_rel_o=0.
- R4: While ovp_i or uvp_i is 1 (and therm_shut_i is 0), the outputs are stage_en_o=0, hiz_o=1, mute50_o=0, diag_rel_o=1. Once both flags clear, the block returns to the mode given by wake_i and unmute_i without any other action.
- R5: ocp_i=1 moves the block to overcurrent wait: stage_en_o=0, hiz_o=1, diag_rel_o=1. After RETRY_CYCLES cycles the block spends exactly one probe cycle with stage_en_o=1, hiz_o=0, mute50_o=1, diag_rel_o=1, so probes repeat every RETRY_CYCLES+1 cycles. If the flag is still set during the probe, the wait starts again. If it is clear, normal mode resumes.
- R6: therm_shut_i=1 overrides every other input and gives stage_en_o=0, hiz_o=1, mute50_o=0, diag_rel_o=1. The block restarts once the flag clears.
- R7: therm_warn_i=1 with wake_i=1 and no higher fault gives stage_en_o=1, hiz_o=0, mute50_o=1, diag_rel_o=1, whatever the value of unmute_i.
- R8: Priority from highest to lowest is: thermal shutdown, supply fault, overcurrent, standby (wake_i=0), thermal warning, mute, play.
- R9: An input change driven between clock edges first shows on the outputs after the third following rising edge, and not after the second.
- R10: During and directly after reset the outputs take the standby values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Mode request: 0 selects standby |
| unmute_i | input | 1 | Mode request: 0 selects mute when awake |
| ovp_i | input | 1 | Supply overvoltage flag |
| uvp_i | input | 1 | Supply undervoltage flag |
| ocp_i | input | 1 | Output overcurrent flag |
| therm_warn_i | input | 1 | Thermal warning flag |
| therm_shut_i | input | 1 | Thermal shutdown flag |
| stage_en_o | output | 1 | Power stage enable |
| hiz_o | output | 1 | Output bridge high-impedance command |
| mute50_o | output | 1 | Force both PWM outputs to 50% duty |
| diag_rel_o | output | 1 | 1 = diagnostic pin released, 0 = pulled low |

## Verification
The bench measures the overcurrent probe period cycle by cycle. A timer that is off by one would show up as a period other than RETRY_CYCLES+1, and a probe that does not re-check the flag would let the stage run on with the fault still present. It checks that unmute_i has no effect in standby and that a thermal warning masks it too, so a wrong priority order would surface as play or mute where standby or warning mute is expected. The synchroniser depth is measured exactly: one flop too few would change the outputs a cycle early. Random mixes of all seven inputs are compared against a priority model, which catches any fault class recovering the wrong way.

// File: rtl/amp_sup_pkg.sv
package amp_sup_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_MUTE,
        ST_PLAY,
        ST_WARN_MUTE,
        ST_FLT_SUPPLY,
        ST_FLT_THERM,
        ST_OC_WAIT,
        ST_OC_PROBE
    } amp_state_e;

    typedef struct packed {
        logic wake;
        logic unmute;
        logic ovp;
        logic uvp;
        logic ocp;
        logic twarn;
        logic tshut;
    } amp_in_t;

    localparam int unsigned AMP_IN_W = $bits(amp_in_t);

endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
    parameter int unsigned WIDTH  = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/amp_retry_timer.sv
module amp_retry_timer #(
    parameter int unsigned RETRY_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic counting_i,
    output logic expired_o
);

    localparam int unsigned CNT_W = $clog2(RETRY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (counting_i) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign expired_o = counting_i && (cnt_q == LAST);

    // the count never runs past the wait length while counting
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (counting_i && !expired_o) |=> (cnt_q <= LAST)); // R5

endmodule

// File: rtl/amp_mode_fsm.sv
module amp_mode_fsm
    import amp_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  amp_in_t    in_s,
    input  logic       expired_i,
    output amp_state_e state_o,
    output logic       stage_en_o,
    output logic       hiz_o,
    output logic       mute50_o,
    output logic       diag_rel_o
);

    amp_state_e state_q, state_d, mode_sel;

    // decode of the mode pins and thermal warning, below every hard fault
    always_comb begin
        if (!in_s.wake) begin
            mode_sel = ST_STANDBY;
        end else if (in_s.twarn) begin
            mode_sel = ST_WARN_MUTE;
        end else if (!in_s.unmute) begin
            mode_sel = ST_MUTE;
        end else begin
            mode_sel = ST_PLAY;
        end
    end

    always_comb begin
        state_d = state_q;
        if (in_s.tshut) begin
            state_d = ST_FLT_THERM;
        end else if (in_s.ovp || in_s.uvp) begin
            state_d = ST_FLT_SUPPLY;
        end else begin
            unique case (state_q)
                ST_OC_WAIT:  state_d = expired_i ? ST_OC_PROBE : ST_OC_WAIT;
                ST_OC_PROBE: state_d = in_s.ocp ? ST_OC_WAIT : mode_sel;
                default:     state_d = in_s.ocp ? ST_OC_WAIT : mode_sel;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STANDBY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stage_en_o = 1'b0;
        hiz_o      = 1'b1;
        mute50_o   = 1'b0;
        diag_rel_o = 1'b0;
        unique case (state_q)
            ST_STANDBY: begin
            end
            ST_MUTE: begin
                stage_en_o = 1'b1;
                hiz_o      = 1'b0;
                mute50_o   = 1'b1;
            end
            ST_PLAY: begin
                stage_en_o = 1'b1;
                hiz_o      = 1'b0;
            end
            ST_WARN_MUTE: begin
                stage_en_o = 1'b1;
                hiz_o      = 1'b0;
                mute50_o   = 1'b1;
                diag_rel_o = 1'b1;
            end
            ST_FLT_SUPPLY, ST_FLT_THERM, ST_OC_WAIT: begin
                diag_rel_o = 1'b1;
            end
            ST_OC_PROBE: begin
                stage_en_o = 1'b1;
                hiz_o      = 1'b0;
                mute50_o   = 1'b1;
                diag_rel_o = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

    AST_TSHUT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        in_s.tshut |=> (state_q == ST_FLT_THERM)); // R6

    AST_SUPPLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_s.tshut && (in_s.ovp || in_s.uvp)) |=> (state_q == ST_FLT_SUPPLY)); // R4

    AST_PROBE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OC_PROBE && in_s.ocp && !in_s.tshut && !in_s.ovp && !in_s.uvp)
        |=> (state_q == ST_OC_WAIT)); // R5

    AST_PROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OC_PROBE) |=> (state_q != ST_OC_PROBE)); // R5

    AST_STBY_OVER_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_s.tshut && !in_s.ovp && !in_s.uvp && !in_s.ocp && !in_s.wake
         && state_q != ST_OC_WAIT && state_q != ST_OC_PROBE)
        |=> (state_q == ST_STANDBY)); // R8

    AST_WARN_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_s.tshut && !in_s.ovp && !in_s.uvp && !in_s.ocp && in_s.wake && in_s.twarn
         && state_q != ST_OC_WAIT && state_q != ST_OC_PROBE)
        |=> (state_q == ST_WARN_MUTE)); // R7

endmodule

// File: rtl/amp_supervisor.sv
module amp_supervisor
    import amp_sup_pkg::*;
#(
    parameter int unsigned RETRY_CYCLES = 1024,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_i,
    input  logic unmute_i,
    input  logic ovp_i,
    input  logic uvp_i,
    input  logic ocp_i,
    input  logic therm_warn_i,
    input  logic therm_shut_i,
    output logic stage_en_o,
    output logic hiz_o,
    output logic mute50_o,
    output logic diag_rel_o
);

    amp_in_t    raw_in, sync_in;
    amp_state_e state;
    logic       expired;

    assign raw_in = '{wake: wake_i, unmute: unmute_i, ovp: ovp_i, uvp: uvp_i,
                      ocp: ocp_i, twarn: therm_warn_i, tshut: therm_shut_i};

    amp_sync #(
        .WIDTH  (AMP_IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    amp_retry_timer #(
        .RETRY_CYCLES (RETRY_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .counting_i (state == ST_OC_WAIT),
        .expired_o  (expired)
    );

    amp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_s       (sync_in),
        .expired_i  (expired),
        .state_o    (state),
        .stage_en_o (stage_en_o),
        .hiz_o      (hiz_o),
        .mute50_o   (mute50_o),
        .diag_rel_o (diag_rel_o)
    );

endmodule

// File: tb/amp_supervisor_bench.sv
module amp_supervisor_bench;

    localparam int unsigned RETRY = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 0, unmute = 0, ovp = 0, uvp = 0, ocp = 0, twarn = 0, tshut = 0;
    logic stage_en, hiz, mute50, diag_rel;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    amp_supervisor #(.RETRY_CYCLES(RETRY)) u_amp_supervisor (
        .clk(clk), .rst_n(rst_n), .wake_i(wake), .unmute_i(unmute),
        .ovp_i(ovp), .uvp_i(uvp), .ocp_i(ocp), .therm_warn_i(twarn),
        .therm_shut_i(tshut), .stage_en_o(stage_en), .hiz_o(hiz),
        .mute50_o(mute50), .diag_rel_o(diag_rel));

    // {stage_en, hiz, mute50, diag_rel} for a settled state without overcurrent
    function automatic logic [3:0] model(input logic w, input logic u, input logic ov,
                                         input logic uv, input logic tw, input logic ts);
        if (ts || ov || uv) return 4'b0101;
        if (!w)             return 4'b0100;
        if (tw)             return 4'b1011;
        if (!u)             return 4'b1010;
        return 4'b1000;
    endfunction

    function automatic logic [3:0] outs();
        return {stage_en, hiz, mute50, diag_rel};
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic u, input logic ov, input logic uv,
                         input logic oc, input logic tw, input logic ts);
        @(negedge clk);
        wake = w; unmute = u; ovp = ov; uvp = uv; ocp = oc; twarn = tw; tshut = ts;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd42));
        // R10 reset state
        hold(2);
        chk("R10 in reset", outs(), 4'b0100);
        rst_n = 1'b1;
        hold(4);
        chk("R10 after reset", outs(), 4'b0100);

        // R1 unmute ignored in standby
        drive(0, 1, 0, 0, 0, 0, 0); hold(5);
        chk("R1 standby unmute=1", outs(), 4'b0100);
        drive(0, 0, 0, 0, 0, 0, 0); hold(5);
        chk("R1 standby unmute=0", outs(), 4'b0100);

        // R2, R3
        drive(1, 0, 0, 0, 0, 0, 0); hold(5);
        chk("R2 mute", outs(), 4'b1010);
        drive(1, 1, 0, 0, 0, 0, 0); hold(5);
        chk("R3 play", outs(), 4'b1000);

        // R9 latency: old value after two edges, new value after three
        drive(0, 1, 0, 0, 0, 0, 0);
        hold(2);
        chk("R9 before third edge", outs(), 4'b1000);
        hold(1);
        chk("R9 at third edge", outs(), 4'b0100);

        // R7 warning masks unmute, standby beats warning (R8)
        drive(1, 1, 0, 0, 0, 1, 0); hold(5);
        chk("R7 warn mute", outs(), 4'b1011);
        drive(0, 1, 0, 0, 0, 1, 0); hold(5);
        chk("R8 standby over warn", outs(), 4'b0100);

        // R4 supply faults and automatic release
        drive(1, 1, 1, 0, 0, 0, 0); hold(5);
        chk("R4 overvoltage", outs(), 4'b0101);
        drive(1, 1, 0, 1, 0, 0, 0); hold(5);
        chk("R4 undervoltage", outs(), 4'b0101);
        drive(1, 1, 0, 0, 0, 0, 0); hold(5);
        chk("R4 release to play", outs(), 4'b1000);

        // R6 thermal shutdown over supply and overcurrent
        drive(1, 1, 1, 0, 1, 1, 1); hold(5);
        chk("R6 shutdown wins", outs(), 4'b0101);
        drive(1, 0, 0, 0, 0, 0, 0); hold(5);
        chk("R6 restart to mute", outs(), 4'b1010);

        // R5 retry period with flag held
        drive(1, 1, 0, 0, 1, 0, 0); hold(4);
        chk("R5 overcurrent wait", outs(), 4'b0101);
        begin
            int guard = 0;
            int period = 0;
            while (!stage_en && guard < 4 * RETRY) begin hold(1); guard++; end
            chk("R5 probe outputs", outs(), 4'b1011);
            hold(1);
            chk("R5 back to wait", outs(), 4'b0101);
            period = 1;
            while (!stage_en && period < 4 * RETRY) begin hold(1); period++; end
            checks++;
            if (period != RETRY + 1) begin
                errors++;
                $display("FAIL R5 probe period actual=%0d expected=%0d", period, RETRY + 1);
            end
        end
        // clear flag: recovery at the next probe
        ocp = 1'b0;
        hold(RETRY + 6);
        chk("R5 recovery to play", outs(), 4'b1000);

        // R8 random mixes against the priority model
        for (int i = 0; i < 80; i++) begin
            logic w, u, ov, uv, oc, tw, ts;
            logic [3:0] o;
            w  = ($urandom % 4) != 0;
            u  = $urandom % 2;
            ov = ($urandom % 8) == 0;
            uv = ($urandom % 8) == 0;
            oc = ($urandom % 6) == 0;
            tw = ($urandom % 5) == 0;
            ts = ($urandom % 10) == 0;
            drive(w, u, ov, uv, oc, tw, ts);
            hold(2 * RETRY + 4);
            o = outs();
            if (oc && !ts && !ov && !uv) begin
                chk("R8 random overcurrent", o, o[3] ? 4'b1011 : 4'b0101);
            end else begin
                chk("R8 random", o, model(w, u, ov, uv, tw, ts));
            end
        end

        finish_run();
    end

endmodule